// File: doc/BRIEF.md
# Product Term Cluster Allocator

This combinational block sits between the product-term array and the sixteen macrocells of one logic block. It receives 80 product-term values in sixteen groups of five, called clusters. Cluster k owns terms 5k to 5k+4. Each cluster ORs its terms into a five-input sum. That sum always leaves the block on a fast bypass output for narrow functions. Inside the block it is steered to one nearby macrocell. Two terms of each cluster can be taken out of the sum and used as that cluster's individual clock term and initialization/clock-enable term.

Clusters can reach their own macrocell, the macrocell above, or one of the two macrocells below. A macrocell can therefore collect up to four clusters, which gives a function of up to 20 terms. An allocator's result can also be forwarded to the allocator four slices further on, wrapping from slice 15 back to slice 0. Such chains reach up to 80 terms. Any macrocell whose allocator forwards its result receives a constant zero. All configuration inputs are treated as static.

Top module: `pt_cluster_steer`

## Requirements
- R1: Cluster k owns bits 5k to 5k+4 of `pt_in`. `fast_sum[k]` is the OR of all of those bits that are not claimed for control.
- R2: With `clk_claim[k]`=1, bit 5k+1 leaves the OR and appears on `ctl_clk[k]`. With `clk_claim[k]`=0, `ctl_clk[k]` is 0.
- R3: With `init_claim[k]`=1, bit 5k+2 leaves the OR and appears on `ctl_init[k]`. With `init_claim[k]`=0, `ctl_init[k]` is 0.
- R4: The field `route_sel[2k+1:2k]` picks the target macrocell of cluster k: 0 gives k, 1 gives k+1, 2 gives k-1, 3 gives k-2. A macrocell's local sum is the OR of the cluster sums routed to it.
- R5: A route code whose target is below 0 or above 15 connects cluster k to no macrocell. `fast_sum[k]` is unaffected.
- R6: A cluster contributes to exactly one macrocell at most. Every other macrocell stays free of it.
- R7: With `chain_fwd[m]`=1, `mc_sum[m]` is 0 and the allocator result of slice m is ORed into the allocator of slice (m+4) mod 16. Forwarding passes on through consecutive forwarding slices, so a slice that does not forward collects the results of up to three slices before it in its chain.
- R8: A chain in which all four slices forward has no exit. All four of its `mc_sum` bits are 0.
- R9: `fast_sum`, `ctl_clk` and `ctl_init` do not depend on `route_sel` or `chain_fwd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pt_in | input | 80 | Product-term values; cluster k in bits 5k+4:5k |
| route_sel | input | 32 | Two-bit target code per cluster |
| clk_claim | input | 16 | Per cluster: use term 5k+1 as clock term |
| init_claim | input | 16 | Per cluster: use term 5k+2 as init/clock-enable term |
| chain_fwd | input | 16 | Per slice: forward allocator result to slice +4 |
| mc_sum | output | 16 | Sum input to each macrocell |
| fast_sum | output | 16 | Per-cluster five-term bypass sum |
| ctl_clk | output | 16 | Per-cluster individual clock term |
| ctl_init | output | 16 | Per-cluster individual init/clock-enable term |

## Verification
The assertions assume that every input is known and is held still while outputs are judged. Configuration is static in real use, and the checks are skipped whenever an input carries X. The stimulus changes all inputs together on the falling edge of the bench clock and compares outputs a quarter period later. Random vectors include out-of-range route codes and closed chains, so illegal settings are exercised under the same assumptions.

// File: rtl/pt_cluster_steer.sv
module pt_cluster_steer #(
  parameter int NUM_MC     = 16,
  parameter int CL_SIZE    = 5,
  parameter int CHAIN_STEP = 4
) (
  input  logic [NUM_MC*CL_SIZE-1:0] pt_in,
  input  logic [2*NUM_MC-1:0]       route_sel,
  input  logic [NUM_MC-1:0]         clk_claim,
  input  logic [NUM_MC-1:0]         init_claim,
  input  logic [NUM_MC-1:0]         chain_fwd,
  output logic [NUM_MC-1:0]         mc_sum,
  output logic [NUM_MC-1:0]         fast_sum,
  output logic [NUM_MC-1:0]         ctl_clk,
  output logic [NUM_MC-1:0]         ctl_init
);
  localparam int CHAIN_LEN = NUM_MC / CHAIN_STEP;

  logic [NUM_MC-1:0] dest [NUM_MC];
  logic [NUM_MC-1:0] local_sum;
  logic [NUM_MC-1:0] alloc;

  for (genvar k = 0; k < NUM_MC; k++) begin : g_cl
    logic [CL_SIZE-1:0] terms;
    logic [CL_SIZE-1:0] keep;
    assign terms = pt_in[k*CL_SIZE +: CL_SIZE];

    always_comb begin
      keep    = '1;
      keep[1] = ~clk_claim[k];
      keep[2] = ~init_claim[k];
    end

    assign fast_sum[k] = |(terms & keep);
    assign ctl_clk[k]  = clk_claim[k] & terms[1];
    assign ctl_init[k] = init_claim[k] & terms[2];

    always_comb begin
      int off;
      int tgt;
      case (route_sel[2*k +: 2])
        2'd1:    off = 1;
        2'd2:    off = -1;
        2'd3:    off = -2;
        default: off = 0;
      endcase
      tgt = k + off;
      dest[k] = '0;
      if (tgt >= 0 && tgt < NUM_MC) dest[k][tgt] = 1'b1;
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_MC; m++) begin
      local_sum[m] = 1'b0;
      for (int c = 0; c < NUM_MC; c++)
        local_sum[m] = local_sum[m] | (dest[c][m] & fast_sum[c]);
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_MC; m++) begin
      logic acc;
      int   src;
      acc = 1'b0;
      for (int d = CHAIN_LEN - 1; d >= 1; d--) begin
        src = (m + NUM_MC - d*CHAIN_STEP) % NUM_MC;
        acc = chain_fwd[src] & (local_sum[src] | acc);
      end
      alloc[m] = local_sum[m] | acc;
    end
  end

  assign mc_sum = alloc & ~chain_fwd;
endmodule

module pt_cluster_steer_chk #(
  parameter int NUM_MC     = 16,
  parameter int CL_SIZE    = 5,
  parameter int CHAIN_STEP = 4
) (
  input logic [NUM_MC*CL_SIZE-1:0] pt_in,
  input logic [2*NUM_MC-1:0]       route_sel,
  input logic [NUM_MC-1:0]         clk_claim,
  input logic [NUM_MC-1:0]         init_claim,
  input logic [NUM_MC-1:0]         chain_fwd,
  input logic [NUM_MC-1:0]         mc_sum,
  input logic [NUM_MC-1:0]         fast_sum,
  input logic [NUM_MC-1:0]         ctl_clk,
  input logic [NUM_MC-1:0]         ctl_init
);
  localparam int CHAIN_LEN = NUM_MC / CHAIN_STEP;

  always_comb begin
    if (!$isunknown({pt_in, route_sel, clk_claim, init_claim, chain_fwd})) begin
      for (int k = 0; k < NUM_MC; k++) begin
        a_r2_clk_idle: assert (clk_claim[k] || !ctl_clk[k])
          else $error("R2 ctl_clk active without claim at %0d", k);
        a_r3_init_idle: assert (init_claim[k] || !ctl_init[k])
          else $error("R3 ctl_init active without claim at %0d", k);
        a_r1_sum_needs_term: assert (!fast_sum[k] || |pt_in[k*CL_SIZE +: CL_SIZE])
          else $error("R1 fast_sum high with no term at %0d", k);
        a_r7_fwd_ground: assert (!(chain_fwd[k] && mc_sum[k]))
          else $error("R7 forwarding slice %0d not grounded", k);
      end
      a_r6_single_dest: assert ($countones(mc_sum) <= $countones(fast_sum))
        else $error("R6 more macrocell sums than cluster sums");
      for (int s = 0; s < CHAIN_STEP; s++) begin
        logic closed;
        logic any_out;
        closed  = 1'b1;
        any_out = 1'b0;
        for (int j = 0; j < CHAIN_LEN; j++) begin
          closed  = closed & chain_fwd[s + j*CHAIN_STEP];
          any_out = any_out | mc_sum[s + j*CHAIN_STEP];
        end
        a_r8_closed_chain_zero: assert (!(closed && any_out))
          else $error("R8 closed chain %0d drives a sum", s);
      end
    end
  end
endmodule

bind pt_cluster_steer pt_cluster_steer_chk #(
  .NUM_MC(NUM_MC), .CL_SIZE(CL_SIZE), .CHAIN_STEP(CHAIN_STEP)
) u_chk (.*);

// File: tb/pt_cluster_steer_tb.sv
module pt_cluster_steer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [79:0] pt_in;
  logic [31:0] route_sel;
  logic [15:0] clk_claim, init_claim, chain_fwd;
  logic [15:0] mc_sum, fast_sum, ctl_clk, ctl_init;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  pt_cluster_steer u_dut (
    .pt_in(pt_in), .route_sel(route_sel), .clk_claim(clk_claim),
    .init_claim(init_claim), .chain_fwd(chain_fwd), .mc_sum(mc_sum),
    .fast_sum(fast_sum), .ctl_clk(ctl_clk), .ctl_init(ctl_init)
  );

  function automatic logic [15:0] ref_fast(logic [79:0] p, logic [15:0] ck, logic [15:0] it);
    logic [15:0] r = '0;
    for (int k = 0; k < 16; k++)
      for (int b = 0; b < 5; b++)
        if (p[5*k+b] && !(b == 1 && ck[k]) && !(b == 2 && it[k])) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] ref_mc(logic [15:0] fs, logic [31:0] rt, logic [15:0] fw);
    logic [15:0] loc = '0;
    logic [15:0] r = '0;
    for (int k = 0; k < 16; k++) begin
      int tgt;
      case (rt[2*k +: 2])
        2'd0: tgt = k;
        2'd1: tgt = k + 1;
        2'd2: tgt = k - 1;
        default: tgt = k - 2;
      endcase
      if (fs[k] && tgt >= 0 && tgt <= 15) loc[tgt] = 1'b1;
    end
    for (int m = 0; m < 16; m++) begin
      if (!fw[m]) begin
        int src = m;
        r[m] = loc[m];
        for (int step = 0; step < 3; step++) begin
          src = (src + 12) % 16;
          if (!fw[src]) break;
          r[m] = r[m] | loc[src];
        end
      end
    end
    return r;
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(logic [79:0] p, logic [31:0] rt, logic [15:0] ck,
                       logic [15:0] it, logic [15:0] fw);
    @(negedge clk);
    pt_in = p; route_sel = rt; clk_claim = ck; init_claim = it; chain_fwd = fw;
    #(CLK_PERIOD/4);
  endtask

  task automatic check_all(string tag);
    logic [15:0] ef, ec, ei;
    ef = ref_fast(pt_in, clk_claim, init_claim);
    ec = '0; ei = '0;
    for (int k = 0; k < 16; k++) begin
      ec[k] = clk_claim[k] & pt_in[5*k+1];
      ei[k] = init_claim[k] & pt_in[5*k+2];
    end
    chk({tag, " fast_sum"}, fast_sum, ef);
    chk({tag, " ctl_clk"}, ctl_clk, ec);
    chk({tag, " ctl_init"}, ctl_init, ei);
    chk({tag, " mc_sum"}, mc_sum, ref_mc(ef, route_sel, chain_fwd));
  endtask

  function automatic logic [31:0] rt1(int k, logic [1:0] code);
    logic [31:0] r = '0;
    r[2*k +: 2] = code;
    return r;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    pt_in = '0; route_sel = '0; clk_claim = '0; init_claim = '0; chain_fwd = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive('0, '0, '0, '0, '0);
    chk("R1 reset mc_sum", mc_sum, 16'h0);
    chk("R1 reset fast_sum", fast_sum, 16'h0);
    chk("R2 reset ctl_clk", ctl_clk, 16'h0);
    chk("R3 reset ctl_init", ctl_init, 16'h0);

    drive(80'h1 << 19, '0, '0, '0, '0);
    chk("R1 term 19 fast", fast_sum, 16'h0008);
    chk("R1 term 19 mc", mc_sum, 16'h0008);

    drive(80'h1 << 31, '0, 16'h0040, '0, '0);
    chk("R2 claimed clock out", ctl_clk, 16'h0040);
    chk("R2 claimed term out of sum", fast_sum, 16'h0);
    drive(80'h1 << 31, '0, '0, '0, '0);
    chk("R2 unclaimed term in sum", fast_sum, 16'h0040);
    chk("R2 unclaimed clock low", ctl_clk, 16'h0);

    drive(80'h1 << 47, '0, '0, 16'h0200, '0);
    chk("R3 claimed init out", ctl_init, 16'h0200);
    chk("R3 claimed term out of sum", fast_sum, 16'h0);

    drive(80'h1 << 25, rt1(5, 2'd1), '0, '0, '0);
    chk("R4 route up", mc_sum, 16'h0040);
    drive(80'h1 << 25, rt1(5, 2'd2), '0, '0, '0);
    chk("R4 route down one", mc_sum, 16'h0010);
    drive(80'h1 << 25, rt1(5, 2'd3), '0, '0, '0);
    chk("R6 route down two only", mc_sum, 16'h0008);
    drive((80'h1 << 25) | (80'h1 << 30), rt1(5, 2'd1), '0, '0, '0);
    chk("R4 two clusters merge", mc_sum, 16'h0040);

    drive(80'h1, rt1(0, 2'd2), '0, '0, '0);
    chk("R5 cluster0 below range mc", mc_sum, 16'h0);
    chk("R5 cluster0 fast kept", fast_sum, 16'h0001);
    drive(80'h1 << 75, rt1(15, 2'd1), '0, '0, '0);
    chk("R5 cluster15 above range mc", mc_sum, 16'h0);
    drive(80'h1 << 5, rt1(1, 2'd3), '0, '0, '0);
    chk("R5 cluster1 two below range", mc_sum, 16'h0);

    drive(80'h1 << 60, '0, '0, '0, 16'h1000);
    chk("R7 wrap 12 to 0", mc_sum, 16'h0001);
    drive(80'h1 << 5, '0, '0, '0, 16'h0222);
    chk("R7 three hop chain", mc_sum, 16'h2000);
    drive(80'h1, '0, '0, '0, 16'h1111);
    chk("R8 closed chain", mc_sum, 16'h0);

    drive(80'h1 << 25, rt1(5, 2'd1), '0, '0, 16'h0040);
    chk("R9 fast ignores route/chain", fast_sum, 16'h0020);

    for (int i = 0; i < 3000; i++) begin
      logic [79:0] p;
      p = {$urandom(), $urandom(), $urandom()};
      if (i % 3 == 0) p = p & {$urandom(), $urandom(), $urandom()} & {$urandom(), $urandom(), $urandom()};
      drive(p, $urandom(), 16'($urandom()), 16'($urandom()),
            (i % 5 == 0) ? 16'hffff : 16'($urandom() & $urandom()));
      check_all("R4 R6 R7 R8 R9 random");
    end

    summary();
  end
endmodule